// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block watches the word counts of a receive FIFO and a transmit FIFO and raises an interrupt when either one crosses a level that software has set. The receive side flags an almost-full condition when its count is strictly above the receive threshold. The transmit side flags an almost-empty condition when its count is strictly below the transmit threshold. Both flags are registered level outputs.

Each flag has a small source state machine with two states. SRC_QUIET means the flag is low. SRC_ACTIVE means the flag is high. The RISE transition goes from SRC_QUIET to SRC_ACTIVE when the flag is seen high, and it emits a one-cycle event. The FALL transition goes from SRC_ACTIVE back to SRC_QUIET when the flag is seen low. All other cases hold the current state.

An event latches its bit in a pending-status register: bit 0 for the receive source and bit 1 for the transmit source. Software reads this register to find the cause and writes ones to clear bits. An enable register masks which pending bits reach the single interrupt line. Access is through a simple register port with a 2-bit select:

| Select | Register | Access |
|---|---|---|
| 0 | receive threshold | read/write |
| 1 | transmit threshold | read/write |
| 2 | enable | read/write |
| 3 | pending status | read, write-one-to-clear |

Top module: `fifo_thresh_irq`

## Requirements
- R1: After reset the flags, the irq output, the enable register and the status register are 0. The receive threshold is all ones and the transmit threshold is 0, so neither flag can assert until software programs a threshold.
- R2: rx_almost_full is 1 in the cycle after a clock edge at which rx_count is strictly greater than the receive threshold held before that edge. It is 0 when the count equals or is below the threshold.
- R3: tx_almost_empty is 1 in the cycle after a clock edge at which tx_count is strictly less than the transmit threshold held before that edge. It is 0 when the count equals or is above the threshold.
- R4: A rising flag takes its source from SRC_QUIET to SRC_ACTIVE and sets its status bit (bit 0 for receive, bit 1 for transmit) one clock edge after the flag rises. A flag that stays high sets the bit only once.
- R5: A write to select 3 clears each status bit written with 1. Bits written with 0 keep their value.
- R6: When a set event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R7: irq is the OR of (status AND enable). The enable register is at select 2, bits [1:0], and irq follows any change to status or enable in the same cycle.
- R8: Selects 0 and 1 hold thresholds of the count width. A read returns the written value, with all bits above the count width read as zero. The enable and status registers also read back at selects 2 and 3.
- R9: A status bit is recorded even while its enable bit is 0. Setting the enable bit later raises irq without a new event.
- R10: After a threshold write, the comparison uses the new value from the next edge onward, and a flag already set follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for the selected register (combinational) |
| rx_count | input | RX_CNT_W | Receive FIFO word count |
| tx_count | input | TX_CNT_W | Transmit FIFO word count |
| rx_almost_full | output | 1 | Receive count above threshold |
| tx_almost_empty | output | 1 | Transmit count below threshold |
| irq | output | 1 | Interrupt: any pending, enabled source |

## Verification
The counts are swept through threshold-1, threshold and threshold+1. This separates strict from non-strict comparisons, and it separates above-threshold from below-threshold logic. The thresholds are also set to their extremes (all ones and zero), where a wrong comparison would fire from reset. Directed runs cover a flag that stays high across a clear, which shows edge-triggered setting apart from level-triggered setting, a clear that lands at the same edge as a set, and writes of 0 to pending bits. They also cover masking with the enable bits, including a source that becomes pending while masked. A long run of random counts and register writes near the thresholds is compared cycle by cycle against a behavioural model of every output.

// File: rtl/fti_pkg.sv
package fti_pkg;
    localparam int NSRC   = 2;
    localparam int SRC_RX = 0;
    localparam int SRC_TX = 1;

    typedef enum logic [1:0] {
        SEL_RX_THR   = 2'd0,
        SEL_TX_THR   = 2'd1,
        SEL_IRQ_EN   = 2'd2,
        SEL_IRQ_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SRC_QUIET  = 1'b0,
        SRC_ACTIVE = 1'b1
    } src_state_e;
endpackage

// File: rtl/fti_cmp.sv
module fti_cmp #(
    parameter int CNT_W = 13,
    parameter bit ABOVE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thresh,
    output logic             flag_q
);
    logic hit;

    generate
        if (ABOVE) begin : g_above
            assign hit = count > thresh;
        end else begin : g_below
            assign hit = count < thresh;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= hit;
    end
endmodule

// File: rtl/fti_edge_fsm.sv
module fti_edge_fsm
    import fti_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    output logic evt
);
    src_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_QUIET:  if (flag)  state_d = SRC_ACTIVE;
            SRC_ACTIVE: if (!flag) state_d = SRC_QUIET;
            default:    state_d = SRC_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            SRC_QUIET:  evt = flag;
            SRC_ACTIVE: evt = 1'b0;
            default:    evt = 1'b0;
        endcase
    end

    // R4: a fresh rise of the flag yields an event in that cycle
    p_rise_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> evt);
    // R4: one event per rise, never two in a row
    p_single_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/fti_regs.sv
module fti_regs
    import fti_pkg::*;
#(
    parameter int RX_W  = 13,
    parameter int TX_W  = 13,
    parameter int REG_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NSRC-1:0]   evt,
    output logic [RX_W-1:0]   rx_thr,
    output logic [TX_W-1:0]   tx_thr,
    output logic [NSRC-1:0]   en_q,
    output logic [NSRC-1:0]   stat_q,
    output logic [REG_W-1:0]  rdata
);
    logic wr_rx, wr_tx, wr_en, wr_stat;

    assign wr_rx   = wr && (addr == SEL_RX_THR);
    assign wr_tx   = wr && (addr == SEL_TX_THR);
    assign wr_en   = wr && (addr == SEL_IRQ_EN);
    assign wr_stat = wr && (addr == SEL_IRQ_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_thr <= '1;
            tx_thr <= '0;
            en_q   <= '0;
        end else begin
            if (wr_rx) rx_thr <= wdata[RX_W-1:0];
            if (wr_tx) tx_thr <= wdata[TX_W-1:0];
            if (wr_en) en_q   <= wdata[NSRC-1:0];
        end
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_stat
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    stat_q[i] <= 1'b0;
                else if (evt[i])               stat_q[i] <= 1'b1;
                else if (wr_stat && wdata[i])  stat_q[i] <= 1'b0;
            end

            // R4: an event latches its bit
            p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> stat_q[i]);
            // R4: a clear bit stays clear without an event
            p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!stat_q[i] && !evt[i]) |=> !stat_q[i]);
            // R5: a one clears when no event collides
            p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_stat && wdata[i] && !evt[i]) |=> !stat_q[i]);
            // R5: a zero leaves a set bit alone
            p_zero_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_stat && !wdata[i] && stat_q[i]) |=> stat_q[i]);
        end
    endgenerate

    always_comb begin
        rdata = '0;
        unique case (addr)
            SEL_RX_THR:   rdata = REG_W'(rx_thr);
            SEL_TX_THR:   rdata = REG_W'(tx_thr);
            SEL_IRQ_EN:   rdata = REG_W'(en_q);
            SEL_IRQ_STAT: rdata = REG_W'(stat_q);
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq
    import fti_pkg::*;
#(
    parameter int RX_CNT_W = 13,
    parameter int TX_CNT_W = 13,
    parameter int REG_W    = (RX_CNT_W > TX_CNT_W) ? RX_CNT_W : TX_CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [RX_CNT_W-1:0] rx_count,
    input  logic [TX_CNT_W-1:0] tx_count,
    output logic                rx_almost_full,
    output logic                tx_almost_empty,
    output logic                irq
);
    logic [RX_CNT_W-1:0] rx_thr;
    logic [TX_CNT_W-1:0] tx_thr;
    logic [NSRC-1:0]     flags, evts, en_q, stat_q;

    fti_cmp #(.CNT_W(RX_CNT_W), .ABOVE(1'b1)) u_rx_cmp (
        .clk(clk), .rst_n(rst_n), .count(rx_count), .thresh(rx_thr),
        .flag_q(flags[SRC_RX])
    );

    fti_cmp #(.CNT_W(TX_CNT_W), .ABOVE(1'b0)) u_tx_cmp (
        .clk(clk), .rst_n(rst_n), .count(tx_count), .thresh(tx_thr),
        .flag_q(flags[SRC_TX])
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            fti_edge_fsm u_fsm (
                .clk(clk), .rst_n(rst_n), .flag(flags[i]), .evt(evts[i])
            );
        end
    endgenerate

    fti_regs #(.RX_W(RX_CNT_W), .TX_W(TX_CNT_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .evt(evts), .rx_thr(rx_thr), .tx_thr(tx_thr),
        .en_q(en_q), .stat_q(stat_q), .rdata(reg_rdata)
    );

    assign rx_almost_full  = flags[SRC_RX];
    assign tx_almost_empty = flags[SRC_TX];
    assign irq             = |(stat_q & en_q);

    // R7: with every source masked the line stays low
    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
    // R6: a collision of set and clear leaves the bit pending
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evts[SRC_RX] && reg_wr && reg_addr == SEL_IRQ_STAT && reg_wdata[SRC_RX])
        |=> stat_q[SRC_RX]);
endmodule

// File: tb/tb_fifo_thresh_irq.sv
module tb_fifo_thresh_irq;
    localparam int RXW  = 13;
    localparam int TXW  = 13;
    localparam int RW   = 13;
    localparam int RMAX = (1 << RXW) - 1;
    localparam int TMAX = (1 << TXW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic [RXW-1:0] rx_count = '0;
    logic [TXW-1:0] tx_count = '0;
    logic rx_almost_full, tx_almost_empty, irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_rthr, m_tthr, m_en, m_stat;
    bit m_rf, m_tf, m_ra, m_ta;

    always #2.5 clk = ~clk;

    fifo_thresh_irq #(.RX_CNT_W(RXW), .TX_CNT_W(TXW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_count(rx_count),
        .tx_count(tx_count), .rx_almost_full(rx_almost_full),
        .tx_almost_empty(tx_almost_empty), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit ev_r, ev_t;
        int old_rthr, old_tthr;
        if (!rst_n) begin
            m_rthr = RMAX; m_tthr = 0; m_en = 0; m_stat = 0;
            m_rf = 0; m_tf = 0; m_ra = 0; m_ta = 0;
            return;
        end
        ev_r = !m_ra && m_rf;
        ev_t = !m_ta && m_tf;
        m_ra = m_rf;
        m_ta = m_tf;
        old_rthr = m_rthr;
        old_tthr = m_tthr;
        if (reg_wr && reg_addr == 2'd3) m_stat = m_stat & ~int'(reg_wdata[1:0]);
        if (ev_r) m_stat = m_stat | 1;
        if (ev_t) m_stat = m_stat | 2;
        if (reg_wr && reg_addr == 2'd0) m_rthr = int'(reg_wdata);
        if (reg_wr && reg_addr == 2'd1) m_tthr = int'(reg_wdata);
        if (reg_wr && reg_addr == 2'd2) m_en = int'(reg_wdata[1:0]);
        m_rf = int'(rx_count) > old_rthr;
        m_tf = int'(tx_count) < old_tthr;
    endtask

    task automatic compare();
        int exp_rd;
        case (reg_addr)
            2'd0: exp_rd = m_rthr;
            2'd1: exp_rd = m_tthr;
            2'd2: exp_rd = m_en;
            default: exp_rd = m_stat;
        endcase
        chk("R2", int'(rx_almost_full), int'(m_rf));
        chk("R3", int'(tx_almost_empty), int'(m_tf));
        chk(cur_req, int'(irq), int'((m_stat & m_en) != 0));
        chk(cur_req, int'(reg_rdata), exp_rd);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = RW'(d);
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(int a);
        reg_addr = 2'(a);
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1: reset values readback
        cur_req = "R1";
        rd(0); chk("R1", int'(reg_rdata), RMAX);
        rd(1); chk("R1", int'(reg_rdata), 0);
        rd(2); chk("R1", int'(reg_rdata), 0);
        rx_count = RXW'(RMAX); tx_count = '0;
        repeat (3) rd(3);
        chk("R1", int'(reg_rdata), 0);
        chk("R1", int'(irq), 0);

        // R8: threshold programming and readback
        cur_req = "R8";
        wr(0, 100); wr(1, 20);
        rd(0); chk("R8", int'(reg_rdata), 100);
        rd(1); chk("R8", int'(reg_rdata), 20);
        rx_count = 0; tx_count = 500;
        repeat (2) rd(3);
        wr(3, 3);

        // R2: strict greater-than sweep
        cur_req = "R2";
        wr(2, 3);
        rx_count = 99;  repeat (2) rd(3);
        rx_count = 100; repeat (2) rd(3); chk("R2", int'(rx_almost_full), 0);
        rx_count = 101; step(); chk("R2", int'(rx_almost_full), 1);
        // R4: status bit 0 one edge later
        cur_req = "R4";
        step(); chk("R4", int'(reg_rdata), 1); chk("R7", int'(irq), 1);
        // R5: write 0 keeps, write 1 clears; flag staying high does not re-set
        cur_req = "R5";
        wr(3, 2); rd(3); chk("R5", int'(reg_rdata), 1);
        wr(3, 1); rd(3); chk("R4", int'(reg_rdata), 0);
        repeat (3) rd(3); chk("R4", int'(reg_rdata), 0);

        // R3: strict less-than sweep
        cur_req = "R3";
        tx_count = 21; repeat (2) rd(3);
        tx_count = 20; repeat (2) rd(3); chk("R3", int'(tx_almost_empty), 0);
        tx_count = 19; step(); chk("R3", int'(tx_almost_empty), 1);
        step(); chk("R4", int'(reg_rdata), 2);
        wr(3, 3);

        // R6: clear collides with set event
        cur_req = "R6";
        rx_count = 0; repeat (2) rd(3);
        rx_count = 200; step();
        wr(3, 1);
        rd(3); chk("R6", int'(reg_rdata) & 1, 1);
        wr(3, 3);

        // R9: pending while masked, irq when enabled later
        cur_req = "R9";
        wr(2, 0);
        rx_count = 0; tx_count = 500; repeat (2) rd(3);
        rx_count = 300; repeat (3) rd(3);
        chk("R9", int'(reg_rdata), 1); chk("R9", int'(irq), 0);
        wr(2, 1); chk("R9", int'(irq), 1);
        wr(2, 2); chk("R7", int'(irq), 0);
        wr(3, 3);

        // R10: threshold change moves the flag; extreme thresholds
        cur_req = "R10";
        rx_count = 150; repeat (2) rd(0);
        chk("R10", int'(rx_almost_full), 1);
        wr(0, 150); step(); chk("R10", int'(rx_almost_full), 0);
        wr(1, TMAX); tx_count = TXW'(TMAX - 1); repeat (2) rd(1);
        chk("R10", int'(tx_almost_empty), 1);
        tx_count = TXW'(TMAX); repeat (2) rd(1);
        chk("R10", int'(tx_almost_empty), 0);
        wr(0, RMAX); rx_count = RXW'(RMAX); repeat (2) rd(0);
        chk("R10", int'(rx_almost_full), 0);

        // random run near the thresholds
        cur_req = "R7";
        wr(0, 64); wr(1, 64); wr(2, 3);
        for (int i = 0; i < 2000; i++) begin
            rx_count = RXW'(60 + ($urandom % 9));
            tx_count = TXW'(60 + ($urandom % 9));
            if (($urandom % 4) == 0) begin
                reg_wr = 1'b1;
                reg_addr = 2'($urandom % 4);
                reg_wdata = (reg_addr < 2) ? RW'(60 + ($urandom % 9)) : RW'($urandom % 4);
            end else begin
                reg_wr = 1'b0;
                reg_addr = 2'($urandom % 4);
            end
            step();
        end
        reg_wr = 1'b0;
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule